// File: doc/BRIEF.md
# Interrupt Request Input Stage (Edge/Level, Counted)

This block turns sixteen interrupt lines into the pending-request bits seen by a master and a slave priority resolver. Each line may be shared by several sources, so the block does not hold a single flip-flop per line. It keeps a saturating count of how many sources are currently driving the line. Every clock, each line can receive one event: assert, deassert or pulse. The count changes with the event, and the request bit is set or cleared from how the count moved and from the line's trigger mode.

Trigger mode is set per line through two 8-bit control registers, one for each resolver. Fixed write masks hold certain lines in edge mode, whatever software writes. The downstream logic acknowledges a line when it accepts the interrupt. An acknowledge drops the request bit only when nothing still drives that line. Events for a line are ignored while the resolver that owns it reports that it is not ready.

Top module: `irq_input_stage`

## Requirements
- R1: Each line keeps a CNT_W-bit count. An assert adds one and a deassert subtracts one. At most one event per line is applied per clock, with pulse first, then assert, then deassert, when several strobes are set together.
- R2: An assert at the all-ones count, or a deassert at zero, leaves the count as it is. It raises that line's bit of sat_hi or sat_lo, respectively, for exactly the following cycle. Otherwise both flags are 0.
- R3: The request bit is set when an event moves the count from 0 to 1. In level mode it is also set after any event that leaves the count nonzero.
- R4: When the count moves from 1 to 0, the request bit clears only in level mode. In edge mode it stays set.
- R5: A pulse is an assert followed in the same cycle by a deassert. The deassert is skipped when the assert saturated. With no saturation the count is unchanged, an edge line at zero latches a request, and a level line at zero ends with its request clear.
- R6: A control bit of 1 selects level mode and 0 selects edge mode. A master write stores wdata & 0xF8, so lines 0 to 2 stay edge. A slave write stores wdata & 0xDE, so lines 8 and 13 stay edge. Both registers read back on ctl_m and ctl_s. A new mode applies from the next cycle.
- R7: Lines 0 to 7 drive req_m bits 0 to 7. Lines 8 to 15 drive req_s, with line n on bit n-8.
- R8: An acknowledge of line ack_pin clears its request bit only when that line's count is zero after the same cycle's event.
- R9: While ready_m is low, events on lines 0 to 7 change no count, no request and no flag. ready_s does the same for lines 8 to 15.
- R10: After reset all counts, requests, flags and control bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_assert | input | 16 | Per-line assert strobe |
| ev_deassert | input | 16 | Per-line deassert strobe |
| ev_pulse | input | 16 | Per-line pulse strobe |
| ready_m | input | 1 | Master resolver ready; gates events on lines 0-7 |
| ready_s | input | 1 | Slave resolver ready; gates events on lines 8-15 |
| ctl_wr_m | input | 1 | Write strobe for master mode register |
| ctl_wr_s | input | 1 | Write strobe for slave mode register |
| ctl_wdata | input | 8 | Write data for mode registers |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_pin | input | 4 | Line being acknowledged |
| ctl_m | output | 8 | Master mode register readback |
| ctl_s | output | 8 | Slave mode register readback |
| req_m | output | 8 | Master request vector |
| req_s | output | 8 | Slave request vector |
| sat_hi | output | 16 | Per-line count overflow flag |
| sat_lo | output | 16 | Per-line count underflow flag |

## Verification
The properties take the strobes to be driven cleanly from reset. They treat an acknowledge as the only thing, other than a level-mode falloff, that may remove a request. The properties also expect saturation flags to follow only the strobes that can cause them. The stimulus drives inputs on the falling edge from a fixed seed and keeps event density low, so counts wander near zero and often cross the 0/1 boundary. Directed runs of 256 asserts, deasserts at zero, gated resolvers and masked register writes reach the corners that random traffic seldom hits.

// File: rtl/irq_input_stage.sv
module irq_input_stage #(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ev_assert,
  input  logic [15:0] ev_deassert,
  input  logic [15:0] ev_pulse,
  input  logic        ready_m,
  input  logic        ready_s,
  input  logic        ctl_wr_m,
  input  logic        ctl_wr_s,
  input  logic [7:0]  ctl_wdata,
  input  logic        ack_valid,
  input  logic [3:0]  ack_pin,
  output logic [7:0]  ctl_m,
  output logic [7:0]  ctl_s,
  output logic [7:0]  req_m,
  output logic [7:0]  req_s,
  output logic [15:0] sat_hi,
  output logic [15:0] sat_lo
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);
  localparam logic [7:0] MASK_M = 8'hF8;
  localparam logic [7:0] MASK_S = 8'hDE;

  logic [CNT_W-1:0] cnt_q [16];
  logic [CNT_W-1:0] cnt_d [16];
  logic [15:0] req_q, req_d, shi_d, slo_d, lvl;
  logic [7:0]  lvl_m_q, lvl_s_q;

  assign lvl   = {lvl_s_q, lvl_m_q};
  assign ctl_m = lvl_m_q;
  assign ctl_s = lvl_s_q;
  assign req_m = req_q[7:0];
  assign req_s = req_q[15:8];

  // returns {err, req, cnt}
  function automatic logic [CNT_W+1:0] step(input logic [CNT_W-1:0] c,
                                             input logic r, input logic lv,
                                             input logic up);
    logic [CNT_W-1:0] cn;
    logic e, rn;
    e  = up ? (c == CMAX) : (c == '0);
    cn = e ? c : (up ? c + CONE : c - CONE);
    rn = r;
    if ((c == '0 && cn == CONE) || (cn != '0 && lv)) rn = 1'b1;
    else if (c == CONE && cn == '0 && lv) rn = 1'b0;
    return {e, rn, cn};
  endfunction

  always_comb begin
    logic [CNT_W+1:0] s;
    logic rdy;
    for (int i = 0; i < 16; i++) begin
      cnt_d[i] = cnt_q[i];
      req_d[i] = req_q[i];
      shi_d[i] = 1'b0;
      slo_d[i] = 1'b0;
      s   = '0;
      rdy = (i < 8) ? ready_m : ready_s;
      if (rdy) begin
        if (ev_pulse[i] || ev_assert[i]) begin
          s = step(cnt_q[i], req_q[i], lvl[i], 1'b1);
          shi_d[i] = s[CNT_W+1];
          req_d[i] = s[CNT_W];
          cnt_d[i] = s[CNT_W-1:0];
          if (ev_pulse[i] && !s[CNT_W+1]) begin
            s = step(cnt_d[i], req_d[i], lvl[i], 1'b0);
            slo_d[i] = s[CNT_W+1];
            req_d[i] = s[CNT_W];
            cnt_d[i] = s[CNT_W-1:0];
          end
        end else if (ev_deassert[i]) begin
          s = step(cnt_q[i], req_q[i], lvl[i], 1'b0);
          slo_d[i] = s[CNT_W+1];
          req_d[i] = s[CNT_W];
          cnt_d[i] = s[CNT_W-1:0];
        end
      end
      if (ack_valid && ack_pin == i[3:0] && cnt_d[i] == '0) req_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) cnt_q[i] <= '0;
      req_q   <= '0;
      sat_hi  <= '0;
      sat_lo  <= '0;
      lvl_m_q <= '0;
      lvl_s_q <= '0;
    end else begin
      for (int i = 0; i < 16; i++) cnt_q[i] <= cnt_d[i];
      req_q  <= req_d;
      sat_hi <= shi_d;
      sat_lo <= slo_d;
      if (ctl_wr_m) lvl_m_q <= ctl_wdata & MASK_M;
      if (ctl_wr_s) lvl_s_q <= ctl_wdata & MASK_S;
    end
  end
endmodule

// File: rtl/irq_input_stage_chk.sv
module irq_input_stage_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ev_assert,
  input logic [15:0] ev_pulse,
  input logic        ready_m,
  input logic        ready_s,
  input logic        ack_valid,
  input logic [7:0]  ctl_m,
  input logic [7:0]  ctl_s,
  input logic [7:0]  req_m,
  input logic [7:0]  req_s,
  input logic [15:0] sat_hi,
  input logic [15:0] sat_lo
);
  // R6
  fixed_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_m[2:0] == 3'b0) && (ctl_s[0] == 1'b0) && (ctl_s[5] == 1'b0));

  // R2
  sat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hi & sat_lo) == 16'h0);

  // R2
  sat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hi & ~$past(ev_assert | ev_pulse)) == 16'h0);

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ack_valid) |->
      (($past({req_s, req_m}) & ~$past({ctl_s, ctl_m}) & ~{req_s, req_m}) == 16'h0));

  // R9
  gate_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_m |=> ((req_m & ~$past(req_m)) == 8'h0) && (sat_hi[7:0] == 8'h0) && (sat_lo[7:0] == 8'h0));

  // R9
  gate_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_s |=> ((req_s & ~$past(req_s)) == 8'h0) && (sat_hi[15:8] == 8'h0) && (sat_lo[15:8] == 8'h0));
endmodule

bind irq_input_stage irq_input_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_assert(ev_assert), .ev_pulse(ev_pulse),
  .ready_m(ready_m), .ready_s(ready_s), .ack_valid(ack_valid),
  .ctl_m(ctl_m), .ctl_s(ctl_s), .req_m(req_m), .req_s(req_s),
  .sat_hi(sat_hi), .sat_lo(sat_lo)
);

// File: tb/irq_input_stage_tb.sv
`timescale 1ns/1ps
module irq_input_stage_tb;
  logic clk = 0, rst_n = 0;
  logic [15:0] ev_assert = 0, ev_deassert = 0, ev_pulse = 0;
  logic ready_m = 1, ready_s = 1, ctl_wr_m = 0, ctl_wr_s = 0, ack_valid = 0;
  logic [7:0] ctl_wdata = 0;
  logic [3:0] ack_pin = 0;
  logic [7:0] ctl_m, ctl_s, req_m, req_s;
  logic [15:0] sat_hi, sat_lo;

  always #10 clk = ~clk;

  irq_input_stage u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_cnt [16];
  bit [15:0] m_req, m_shi, m_slo;
  bit [7:0] m_lm, m_ls;
  localparam int CMAX = 255;

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mstep(int i, bit up, bit lv, output bit err);
    int c, cn;
    c = m_cnt[i];
    err = up ? (c == CMAX) : (c == 0);
    cn = err ? c : (up ? c + 1 : c - 1);
    if ((c == 0 && cn == 1) || (cn != 0 && lv)) m_req[i] = 1;
    else if (c == 1 && cn == 0 && lv) m_req[i] = 0;
    m_cnt[i] = cn;
  endtask

  task automatic model();
    bit e;
    bit [15:0] lv;
    lv = {m_ls, m_lm};
    m_shi = 0; m_slo = 0;
    for (int i = 0; i < 16; i++) begin
      if ((i < 8) ? ready_m : ready_s) begin
        if (ev_pulse[i] || ev_assert[i]) begin
          mstep(i, 1, lv[i], e); m_shi[i] = e;
          if (ev_pulse[i] && !e) begin mstep(i, 0, lv[i], e); m_slo[i] = e; end
        end else if (ev_deassert[i]) begin
          mstep(i, 0, lv[i], e); m_slo[i] = e;
        end
      end
      if (ack_valid && ack_pin == 4'(i) && m_cnt[i] == 0) m_req[i] = 0;
    end
    if (ctl_wr_m) m_lm = ctl_wdata & 8'hF8;
    if (ctl_wr_s) m_ls = ctl_wdata & 8'hDE;
  endtask

  task automatic tick(string tag);
    model();
    @(posedge clk); @(negedge clk);
    chk({req_s, req_m} === m_req, tag, {req_s, req_m}, m_req);
    chk(sat_hi === m_shi && sat_lo === m_slo, tag, sat_hi | sat_lo, m_shi | m_slo);
    chk({ctl_s, ctl_m} === {m_ls, m_lm}, tag, {ctl_s, ctl_m}, {m_ls, m_lm});
    ev_assert = 0; ev_deassert = 0; ev_pulse = 0;
    ctl_wr_m = 0; ctl_wr_s = 0; ack_valid = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk({req_s, req_m, ctl_s, ctl_m} === 32'h0, "R10", {req_s, req_m}, 16'h0);
    chk((sat_hi | sat_lo) === 16'h0, "R10", sat_hi | sat_lo, 16'h0);
    // R6 masked writes
    ctl_wr_m = 1; ctl_wr_s = 1; ctl_wdata = 8'hFF; tick("R6");
    ctl_wr_m = 1; ctl_wr_s = 1; ctl_wdata = 8'h20; tick("R6");
    // R3 edge line 4 sets on 0->1; R4 stays after 1->0
    ev_assert[4] = 1; tick("R3");
    ev_deassert[4] = 1; tick("R4");
    // level line 5
    ev_assert[5] = 1; tick("R3");
    ev_deassert[5] = 1; tick("R4");
    // R8 ack clears when count zero, holds when nonzero
    ack_valid = 1; ack_pin = 4; tick("R8");
    ev_assert[6] = 1; tick("R3");
    ack_valid = 1; ack_pin = 6; tick("R8");
    ev_deassert[6] = 1; ack_valid = 1; ack_pin = 6; tick("R8");
    // R2 underflow
    ev_deassert[7] = 1; tick("R2");
    // R2 overflow on line 3
    for (int k = 0; k < 255; k++) begin ev_assert[3] = 1; tick("R1"); end
    ev_assert[3] = 1; tick("R2");
    ev_pulse[3] = 1; tick("R5");
    // R5 pulse on edge and level lines
    ev_pulse[10] = 1; tick("R5");
    ev_deassert[10] = 1; tick("R5");
    ev_pulse[13] = 1; tick("R5");
    ctl_wr_s = 1; ctl_wdata = 8'h08; tick("R6");
    ev_pulse[11] = 1; tick("R5");
    // R1 priority with several strobes
    ev_pulse[12] = 1; ev_assert[12] = 1; ev_deassert[12] = 1; tick("R1");
    ev_assert[14] = 1; ev_deassert[14] = 1; tick("R1");
    // R9 gating
    ready_s = 0; ev_assert[11] = 1; ev_deassert[15] = 1; tick("R9");
    ready_s = 1;
    ready_m = 0; ev_assert[0] = 1; ev_deassert[1] = 1; tick("R9");
    ready_m = 1;
    // R7 slave mapping
    ev_assert[9] = 1; tick("R7");
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < 16; i++) begin
        int r;
        r = $urandom_range(0, 15);
        ev_assert[i]   = (r == 0);
        ev_deassert[i] = (r == 1) || (r == 2);
        ev_pulse[i]    = (r == 3);
      end
      ready_m   = ($urandom_range(0, 9) != 0);
      ready_s   = ($urandom_range(0, 9) != 0);
      ctl_wr_m  = ($urandom_range(0, 30) == 0);
      ctl_wr_s  = ($urandom_range(0, 30) == 0);
      ctl_wdata = 8'($urandom);
      ack_valid = ($urandom_range(0, 3) == 0);
      ack_pin   = 4'($urandom);
      tick("R1 R3 R4 R8 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule